// File: doc/BRIEF.md
# Serial receive FIFO with trigger-level interrupt

This block buffers characters from a serial receiver until the CPU reads them. It holds up to sixteen 11-bit entries in a circular store. Each entry carries an 8-bit character, two error status bits and a break marker bit. A character strobe or a break strobe pushes one entry. A pop strobe, which the register decoder raises on a data-register read, removes the head entry. The head entry is always visible on `pop_data_o`, so the decoder can return it in the same cycle as the pop.

A mode input selects the depth. In buffered mode the block accepts up to sixteen entries. In holding mode it accepts a single character. The block keeps empty and full flags and a ready output that tells the receiver whether a push would be taken. A push made while not ready is dropped and sets a sticky overrun flag.

The receive interrupt request is tied to a trigger level (parameter `TRIG`, default 1). It is raised by the push that brings the count up to `TRIG`. It is lowered only by the pop that brings the count down to `TRIG - 1`. With the default level, the request is high exactly while the buffer holds data.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `rx_irq_o`=0, `overrun_o`=0 and `ready_o`=1.
- R2: Entries are popped in the order they were pushed, including across the wrap of the circular store. A character entry has data in bits 7:0, `char_err_i` in bits 9:8 and 0 in bit 10.
- R3: A `brk_i` pulse pushes the entry 0x400 (bit 10 set, all other bits zero). If `char_vld_i` is high in the same cycle, only the break entry is stored and the character is discarded.
- R4: With `fifo_mode_i`=1, `ready_o` is high while the count is below 16. With `fifo_mode_i`=0, it is high only while the count is 0. The count never exceeds 16.
- R5: A push presented while `ready_o` is low leaves the contents and count unchanged and sets `overrun_o`. `overrun_o` then stays high until reset.
- R6: Every accepted push clears `empty_o`. A pop that leaves the count at zero sets it, so `empty_o` is high exactly when the count is zero.
- R7: `full_o` is set by an accepted push that brings the count to 16, or by any accepted push while `hold_full_i`=1. Any pop without a simultaneous accepted push clears it.
- R8: `rx_irq_o` is set by an accepted push that makes the count equal `TRIG`. It is cleared by a pop that makes the count equal `TRIG`-1. No other event changes it, so it stays high while two entries drain down to one.
- R9: A pop on an empty buffer leaves the read position and count unchanged, and `pop_data_o` keeps showing the stale entry at the read position. The next push writes that same slot.
- R10: A push and a pop in the same cycle act as the pop followed by the push. `pop_data_o` shows the old head before the edge. With one entry held, or with none, the buffer afterwards holds one entry: the pushed one, with `empty_o`=0 and `rx_irq_o`=1.
- R11: `pop_data_o` shows the head entry combinationally, with no extra cycle after a push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_vld_i | input | 1 | Push the received character this cycle |
| char_data_i | input | 8 | Received character |
| char_err_i | input | 2 | Error status stored with the character |
| brk_i | input | 1 | Push a break marker entry this cycle |
| pop_i | input | 1 | Remove the head entry (data-register read) |
| fifo_mode_i | input | 1 | 1: sixteen-entry buffering, 0: single-character holding |
| hold_full_i | input | 1 | 1: every accepted push sets the full flag |
| ready_o | output | 1 | A push would be accepted this cycle |
| pop_data_o | output | 11 | Head entry {break, error[1:0], data[7:0]} |
| empty_o | output | 1 | Buffer empty flag |
| full_o | output | 1 | Buffer full flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| overrun_o | output | 1 | Sticky flag: a push was dropped |

## Verification
The assertions take for granted that every input is a known value on each rising clock edge after reset. They also assume that a push or pop request is a one-cycle strobe per event, so that holding a strobe high for several cycles means several events. The checks on the empty-pop case also rely on the holding state: with `fifo_mode_i` low the count stays at 0 or 1. The bench changes inputs only between clock edges, keeps each strobe high for exactly one cycle, and switches `fifo_mode_i` and `hold_full_i` only while the buffer is empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 2;
  localparam int ENT_W   = DATA_W + ERR_W + 1;
  localparam int BRK_BIT = ENT_W - 1;

  typedef logic [ENT_W-1:0] entry_t;

  function automatic entry_t brk_entry();
    entry_t e;
    e = '0;
    e[BRK_BIT] = 1'b1;
    return e;
  endfunction

  function automatic entry_t char_entry(logic [ERR_W-1:0] err, logic [DATA_W-1:0] dat);
    return {1'b0, err, dat};
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  entry_t           wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output entry_t           rdata_o
);
  entry_t mem_q [DEPTH];

  // storage rows are not reset: stale contents are observable by design
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == PTR_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_req_i,
  input  logic             pop_i,
  input  logic             fifo_mode_i,
  input  logic             hold_full_i,
  output logic             ready_o,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             irq_o,
  output logic             overrun_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG);
  localparam logic [CNT_W-1:0] TRIG_LO = CNT_W'(TRIG - 1);

  logic [CNT_W-1:0] cnt_q, cnt_pop, cnt_nxt, limit;
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_nxt;
  logic [SUM_W-1:0] slot_sum;
  logic             empty_q, full_q, irq_q, ovr_q;
  logic             empty_n, full_n, irq_n;
  logic             push_ok, pop_eff;

  assign limit   = fifo_mode_i ? DEPTH_C : CNT_W'(1);
  assign ready_o = cnt_q < limit;
  assign push_ok = push_req_i && ready_o;
  assign pop_eff = pop_i && (cnt_q != '0);

  assign ptr_inc = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_nxt = pop_eff ? ptr_inc : ptr_q;
  assign cnt_pop = pop_eff ? cnt_q - CNT_W'(1) : cnt_q;
  assign cnt_nxt = cnt_pop + CNT_W'(push_ok);

  // write slot = (read pointer + count) mod DEPTH, same before or after a pop
  assign slot_sum = SUM_W'(ptr_q) + SUM_W'(cnt_q);
  assign waddr_o  = (slot_sum >= SUM_W'(DEPTH)) ? PTR_W'(slot_sum - SUM_W'(DEPTH))
                                                : PTR_W'(slot_sum);
  assign we_o     = push_ok;

  // pop applied first, then push
  always_comb begin
    empty_n = empty_q;
    full_n  = full_q;
    irq_n   = irq_q;
    if (pop_i) begin
      full_n = 1'b0;
      if (cnt_pop == '0)     empty_n = 1'b1;
      if (cnt_pop == TRIG_LO) irq_n  = 1'b0;
    end
    if (push_ok) begin
      empty_n = 1'b0;
      if (cnt_nxt == DEPTH_C || hold_full_i) full_n = 1'b1;
      if (cnt_nxt == TRIG_C) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ptr_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ptr_q   <= ptr_nxt;
      empty_q <= empty_n;
      full_q  <= full_n;
      irq_q   <= irq_n;
      ovr_q   <= ovr_q | (push_req_i & ~ready_o);
    end
  end

  assign rd_ptr_o  = ptr_q;
  assign cnt_o     = cnt_q;
  assign empty_o   = empty_q;
  assign full_o    = full_q;
  assign irq_o     = irq_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_vld_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic [ERR_W-1:0]  char_err_i,
  input  logic              brk_i,
  input  logic              pop_i,
  input  logic              fifo_mode_i,
  input  logic              hold_full_i,
  output logic              ready_o,
  output logic [ENT_W-1:0]  pop_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              rx_irq_o,
  output logic              overrun_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_req, we;
  entry_t           wdata, rdata;
  logic [PTR_W-1:0] waddr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  assign push_req = char_vld_i | brk_i;
  // break wins over a character in the same cycle
  assign wdata    = brk_i ? brk_entry() : char_entry(char_err_i, char_data_i);

  rxq_ctrl #(
    .DEPTH(DEPTH), .TRIG(TRIG), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_req_i  (push_req),
    .pop_i       (pop_i),
    .fifo_mode_i (fifo_mode_i),
    .hold_full_i (hold_full_i),
    .ready_o     (ready_o),
    .we_o        (we),
    .waddr_o     (waddr),
    .rd_ptr_o    (rd_ptr),
    .cnt_o       (cnt),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .irq_o       (rx_irq_o),
    .overrun_o   (overrun_o)
  );

  rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_ptr),
    .rdata_o (rdata)
  );

  assign pop_data_o = rdata;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_vld_i,
  input logic             brk_i,
  input logic             pop_i,
  input logic             ready_o,
  input logic [10:0]      pop_data_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             rx_irq_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] cnt
);
  logic push_req;
  assign push_req = char_vld_i | brk_i;

  // R5
  drop_sets_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && !ready_o) |=> overrun_o);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R6
  push_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && ready_o) |=> !empty_o);

  // R6
  empty_tracks_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (cnt == '0));

  // R7
  pop_clears_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !(push_req && ready_o)) |=> !full_o);

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && ready_o && !pop_i && cnt == CNT_W'(TRIG - 1)) |=> rx_irq_o);

  // R9
  empty_pop_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_req) |=> ($stable(pop_data_o) && empty_o));
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH), .TRIG(TRIG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .char_vld_i (char_vld_i),
  .brk_i      (brk_i),
  .pop_i      (pop_i),
  .ready_o    (ready_o),
  .pop_data_o (pop_data_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .rx_irq_o   (rx_irq_o),
  .overrun_o  (overrun_o),
  .cnt        (cnt)
);

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {brk, vld, err[1:0], data[7:0], expected entry[10:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 2'd0, 8'h41, 11'h041},
    {1'b0, 1'b1, 2'd1, 8'h5A, 11'h15A},
    {1'b1, 1'b1, 2'd2, 8'h77, 11'h400},
    {1'b0, 1'b1, 2'd3, 8'hFF, 11'h3FF},
    {1'b1, 1'b0, 2'd0, 8'h00, 11'h400},
    {1'b0, 1'b1, 2'd2, 8'h00, 11'h200}
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        char_vld = 1'b0, brk = 1'b0, pop = 1'b0;
  logic [7:0]  char_data = '0;
  logic [1:0]  char_err = '0;
  logic        fifo_mode = 1'b1, hold_full = 1'b0;
  logic        ready, empty, full, irq, ovr;
  logic [10:0] pdata;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_fifo_trig u0 (
    .clk_i(clk), .rst_ni(rst_ni), .char_vld_i(char_vld), .char_data_i(char_data),
    .char_err_i(char_err), .brk_i(brk), .pop_i(pop), .fifo_mode_i(fifo_mode),
    .hold_full_i(hold_full), .ready_o(ready), .pop_data_o(pdata), .empty_o(empty),
    .full_o(full), .rx_irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one clock with the given strobes; returns just after the edge
  task automatic step(input logic v, input logic b, input logic [1:0] e,
                      input logic [7:0] d, input logic p);
    char_vld = v; brk = b; char_err = e; char_data = d; pop = p;
    @(posedge clk);
    #1;
    char_vld = 0; brk = 0; pop = 0;
  endtask

  function automatic logic [10:0] fill_ent(int i);
    return {1'b0, 2'(i), 8'((i * 13 + 5) & 255)};
  endfunction

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(empty, 1, "R1 empty"); chk(full, 0, "R1 full"); chk(irq, 0, "R1 irq");
    chk(ovr, 0, "R1 overrun"); chk(ready, 1, "R1 ready");

    // vector table: push all, then drain in order (R2, R3, R11)
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21], VEC[i][22], VEC[i][20:19], VEC[i][18:11], 1'b0);
      if (i == 0) begin
        chk(irq, 1, "R8 irq on first push");
        chk(empty, 0, "R6 empty cleared");
        chk(pdata, VEC[0][10:0], "R11 head visible");
      end
    end
    for (int i = 0; i < NVEC; i++) begin
      chk(pdata, VEC[i][10:0], "R2 R3 pop order/format");
      step(0, 0, 0, 0, 1);
      if (i == 0) chk(irq, 1, "R8 irq held with entries left");
    end
    chk(empty, 1, "R6 empty after drain"); chk(irq, 0, "R8 irq cleared at zero");

    // fill across wrap (R2, R4, R7, R5)
    for (int i = 0; i < 16; i++) begin
      step(1, 0, fill_ent(i)[9:8], fill_ent(i)[7:0], 0);
      if (i == 14) chk(full, 0, "R7 not full at 15");
    end
    chk(full, 1, "R7 full at 16"); chk(ready, 0, "R4 not ready at 16");
    step(1, 0, 2'd3, 8'hEE, 0);
    chk(ovr, 1, "R5 overrun set");
    for (int i = 0; i < 16; i++) begin
      chk(pdata, fill_ent(i), "R2 wrap order");
      step(0, 0, 0, 0, 1);
      if (i == 0) begin
        chk(full, 0, "R7 pop clears full");
        chk(ready, 1, "R4 ready below 16");
      end
    end
    chk(empty, 1, "R5 dropped entry absent"); chk(ovr, 1, "R5 overrun sticky");

    // R9 pop on empty: stale slot 6 holds fill 0
    chk(pdata, fill_ent(0), "R9 stale head");
    step(0, 0, 0, 0, 1);
    chk(pdata, fill_ent(0), "R9 pointer unchanged");
    chk(empty, 1, "R9 empty kept"); chk(irq, 0, "R9 irq kept low");
    step(1, 0, 2'd0, 8'hAA, 0);
    chk(pdata, 11'h0AA, "R9 next push lands at read slot");
    step(0, 0, 0, 0, 1);

    // holding mode (R4, R5)
    do_reset();
    chk(ovr, 0, "R1 overrun after reset");
    fifo_mode = 0;
    step(1, 0, 2'd1, 8'h23, 0);
    chk(ready, 0, "R4 holding mode not ready at 1");
    chk(full, 0, "R7 holding mode no full");
    step(1, 0, 2'd0, 8'hBB, 0);
    chk(ovr, 1, "R5 holding overrun");
    chk(pdata, 11'h123, "R5 content unchanged");
    step(0, 0, 0, 0, 1);
    chk(empty, 1, "R6 empty after single pop"); chk(ready, 1, "R4 ready at 0");

    // R7 hold_full
    hold_full = 1;
    step(1, 0, 2'd0, 8'hCC, 0);
    chk(full, 1, "R7 hold_full sets full");
    step(0, 0, 0, 0, 1);
    chk(full, 0, "R7 pop clears full");
    hold_full = 0; fifo_mode = 1;

    // R10 simultaneous push and pop
    step(1, 0, 2'd0, 8'h11, 0);
    chk(pdata, 11'h011, "R10 old head before edge");
    step(1, 0, 2'd0, 8'h22, 1);
    chk(empty, 0, "R10 empty after push+pop"); chk(irq, 1, "R10 irq kept");
    chk(pdata, 11'h022, "R10 pushed entry is head");
    step(0, 0, 0, 0, 1);
    chk(empty, 1, "R10 drained"); chk(irq, 0, "R10 irq cleared");
    step(1, 0, 2'd0, 8'h33, 1);
    chk(empty, 0, "R10 push+pop on empty"); chk(irq, 1, "R10 irq on empty push+pop");
    chk(pdata, 11'h033, "R10 entry stored");
    step(0, 0, 0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule